// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block is a direct-mapped data cache that sits between a processor load/store port and a simple word-wide memory port. It holds 32 lines of 32 bytes (1 KB total). For every line it keeps a valid flag and a tag. Reads that hit return their word in the same cycle. A read miss stalls the processor and fetches the whole line from memory. After the fill, the held read completes as a hit.

Stores follow a write-through, no-allocate policy. A store is first checked against the tag. If it hits, only the enabled bytes of the addressed word are changed. Hit or miss, every store is pushed into a four-entry store FIFO. That FIFO drains to memory one entry at a time, in order, without involving the processor. The processor waits on a store only when the FIFO is full. A read miss holds back its line request until the FIFO is empty, so a fill never returns data that is older than a store the processor has already issued.

The controller is a four-state machine:

- **IDLE**: serves hits and accepts stores while the FIFO drains.
- **DRAIN**: a read miss is waiting for the FIFO to empty. The FIFO keeps draining.
- **FILL_REQ**: the line request is offered to memory.
- **FILL_BEAT**: the eight response words are collected.

Its transitions are:

- **IDLE → DRAIN** on a read miss.
- **DRAIN → FILL_REQ** once the FIFO is empty.
- **FILL_REQ → FILL_BEAT** when memory accepts the request.
- **FILL_BEAT → IDLE** on the eighth response word.

Top module: `wtc_cache`

## Requirements
- R1: An address splits into tag [31:10], line index [9:5], word select [4:2] and byte lane [1:0]. A lookup hits when the indexed line is valid and its stored tag equals the address tag. A read hit returns the word in the same cycle with `cpu_stall` low. A read to the same index with a different tag misses.
- R2: After reset every line is invalid. With no request pending, `cpu_stall` and `mem_req_valid` are low, and the first read of any address misses.
- R3: A read miss holds `cpu_stall` high and issues exactly one memory read request (`mem_req_write`=0) whose address has bits [4:0] zero. The eight following `mem_rsp_valid` words are stored as words 0 to 7 in that order. The line becomes valid after the eighth word, and the held read then completes with the filled data.
- R4: A store that hits changes only the bytes whose enable bit is set. `cpu_be[i]` covers data bits [8i+7:8i]. All other bytes of the line keep their value.
- R5: A store that misses does not fetch or allocate the line. A later read of that address misses and returns the stored value from memory.
- R6: Every accepted store produces exactly one memory write (`mem_req_write`=1) with the store's address, data and byte enables. Writes reach memory in the order the stores were accepted.
- R7: The store FIFO holds four entries. Up to four stores are accepted with no stall while memory accepts nothing. A fifth store stalls until an entry has been written to memory, and is then accepted.
- R8: A line read request is never issued while any accepted store is still unwritten. A read miss never produces a memory write of its own.
- R9: Once `mem_req_valid` is high it stays high, with address and direction unchanged, until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access valid, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid when stall is low |
| cpu_hit | output | 1 | Lookup hit for the current access |
| cpu_stall | output | 1 | Access not completed this cycle |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Fill response word valid |
| mem_rsp_data | input | 32 | Fill response word |

## Verification
The bench builds the block with its default geometry: 32 lines of 8 words and a four-entry store FIFO. At that size a sweep can fill and re-read every line and every word, and can run all 16 byte-enable patterns against cached words. Because the FIFO has only four entries, the bench can saturate it by withholding memory acceptance, and can hold a read miss behind a pending store, which makes the drain-before-fill ordering visible. An alternating acceptance pattern then exercises request holding while writes and fills interleave.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int WTC_AW = 32;
    localparam int WTC_DW = 32;
    localparam int WTC_BW = WTC_DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FILL_REQ,
        ST_FILL_BEAT
    } wtc_state_e;

    typedef struct packed {
        logic [WTC_AW-1:0] addr;
        logic [WTC_DW-1:0] data;
        logic [WTC_BW-1:0] be;
    } wtc_store_t;

endpackage

// File: rtl/wtc_store_fifo.sv
module wtc_store_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = slot_q[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_q] <= push_data;
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES  = 32,
    parameter int WORDS  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] lk_idx,
    input  logic [$clog2(WORDS)-1:0] lk_word,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    output logic [DATA_W-1:0]        lk_data,
    input  logic                     st_we,
    input  logic [DATA_W/8-1:0]      st_be,
    input  logic [DATA_W-1:0]        st_data,
    input  logic [$clog2(LINES)-1:0] fill_idx,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic                     fill_start,
    input  logic                     fill_we,
    input  logic [$clog2(WORDS)-1:0] fill_word,
    input  logic [DATA_W-1:0]        fill_data,
    input  logic                     fill_done
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] data_q [LINES][WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data = data_q[lk_idx][lk_word];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_start) begin
            valid_q[fill_idx] <= 1'b0;
        end else if (fill_done) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_start) tag_q[fill_idx] <= fill_tag;
        if (fill_we) begin
            data_q[fill_idx][fill_word] <= fill_data;
        end else if (st_we) begin
            for (int b = 0; b < BE_W; b++) begin
                if (st_be[b]) data_q[lk_idx][lk_word][8*b +: 8] <= st_data[8*b +: 8];
            end
        end
    end

    a_r3_valid_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> valid_q[$past(fill_idx)]);
    a_r3_fill_not_store: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !st_we);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int LINE_W = 27
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [LINE_W-1:0]        cpu_line,
    input  logic                     lookup_hit,
    input  logic                     fifo_empty,
    input  logic                     fifo_full,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    output logic                     cpu_stall,
    output logic                     push,
    output logic                     store_we,
    output logic                     rd_req,
    output logic                     drain_en,
    output logic                     fill_start,
    output logic                     fill_we,
    output logic                     fill_done,
    output logic [$clog2(WORDS)-1:0] fill_word,
    output logic [LINE_W-1:0]        fill_line
);
    localparam int WRD_W = $clog2(WORDS);

    wtc_state_e        state_q, state_d;
    logic [WRD_W-1:0]  beat_q;
    logic [LINE_W-1:0] line_q;
    logic              rd_miss;

    assign rd_miss   = cpu_req && !cpu_we && !lookup_hit;
    assign fill_word = beat_q;
    assign fill_line = line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && rd_miss) line_q <= cpu_line;
            if (state_q == ST_FILL_REQ) beat_q <= '0;
            else if (state_q == ST_FILL_BEAT && mem_rsp_valid) beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (rd_miss) state_d = ST_DRAIN;
            ST_DRAIN:     if (fifo_empty) state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_BEAT;
            ST_FILL_BEAT: if (mem_rsp_valid && beat_q == WRD_W'(WORDS - 1)) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_stall  = 1'b0;
        push       = 1'b0;
        store_we   = 1'b0;
        rd_req     = 1'b0;
        drain_en   = 1'b0;
        fill_start = 1'b0;
        fill_we    = 1'b0;
        fill_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                drain_en = 1'b1;
                if (cpu_req && cpu_we) begin
                    cpu_stall = fifo_full;
                    push      = !fifo_full;
                    store_we  = lookup_hit && !fifo_full;
                end else if (rd_miss) begin
                    cpu_stall = 1'b1;
                end
            end
            ST_DRAIN: begin
                cpu_stall = 1'b1;
                drain_en  = 1'b1;
            end
            ST_FILL_REQ: begin
                cpu_stall  = 1'b1;
                rd_req     = 1'b1;
                fill_start = mem_req_ready;
            end
            ST_FILL_BEAT: begin
                cpu_stall = 1'b1;
                fill_we   = mem_rsp_valid;
                fill_done = mem_rsp_valid && (beat_q == WRD_W'(WORDS - 1));
            end
        endcase
    end

    a_r8_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> fifo_empty);
    a_r3_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL_BEAT && !mem_rsp_valid) |=> $stable(beat_q));
    a_r8_no_push_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !push);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 32,
    parameter int BUF_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WTC_AW-1:0] cpu_addr,
    input  logic [WTC_DW-1:0] cpu_wdata,
    input  logic [WTC_BW-1:0] cpu_be,
    output logic [WTC_DW-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WTC_AW-1:0] mem_req_addr,
    output logic [WTC_DW-1:0] mem_req_wdata,
    output logic [WTC_BW-1:0] mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [WTC_DW-1:0] mem_rsp_data
);
    localparam int WORDS  = LINE_BYTES / WTC_BW;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WRD_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int LINE_W = WTC_AW - OFF_W;
    localparam int TAG_W  = LINE_W - IDX_W;
    localparam int ENT_W  = $bits(wtc_store_t);

    logic              lookup_hit, push, store_we, rd_req, drain_en;
    logic              fill_start, fill_we, fill_done, fifo_empty, fifo_full, pop;
    logic [WRD_W-1:0]  fill_word;
    logic [LINE_W-1:0] fill_line, cpu_line;
    wtc_store_t        new_ent, head_ent;
    logic [ENT_W-1:0]  head_bits;

    assign cpu_line = cpu_addr[WTC_AW-1:OFF_W];
    assign new_ent  = '{addr: cpu_addr, data: cpu_wdata, be: cpu_be};
    assign head_ent = wtc_store_t'(head_bits);
    assign cpu_hit  = cpu_req && lookup_hit;

    wtc_line_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(WTC_DW)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (cpu_addr[OFF_W +: IDX_W]),
        .lk_word   (cpu_addr[2 +: WRD_W]),
        .lk_tag    (cpu_addr[WTC_AW-1 -: TAG_W]),
        .lk_hit    (lookup_hit),
        .lk_data   (cpu_rdata),
        .st_we     (store_we),
        .st_be     (cpu_be),
        .st_data   (cpu_wdata),
        .fill_idx  (fill_line[IDX_W-1:0]),
        .fill_tag  (fill_line[LINE_W-1:IDX_W]),
        .fill_start(fill_start),
        .fill_we   (fill_we),
        .fill_word (fill_word),
        .fill_data (mem_rsp_data),
        .fill_done (fill_done)
    );

    wtc_store_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(ENT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(new_ent),
        .pop      (pop),
        .head     (head_bits),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    wtc_ctrl #(.WORDS(WORDS), .LINE_W(LINE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_line     (cpu_line),
        .lookup_hit   (lookup_hit),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .cpu_stall    (cpu_stall),
        .push         (push),
        .store_we     (store_we),
        .rd_req       (rd_req),
        .drain_en     (drain_en),
        .fill_start   (fill_start),
        .fill_we      (fill_we),
        .fill_done    (fill_done),
        .fill_word    (fill_word),
        .fill_line    (fill_line)
    );

    assign mem_req_valid = rd_req || (drain_en && !fifo_empty);
    assign mem_req_write = !rd_req;
    assign mem_req_addr  = rd_req ? {fill_line, {OFF_W{1'b0}}} : head_ent.addr;
    assign mem_req_wdata = head_ent.data;
    assign mem_req_be    = rd_req ? '1 : head_ent.be;
    assign pop           = drain_en && !fifo_empty && mem_req_ready;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
    a_r1_hit_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_hit) |-> !cpu_stall);
endmodule

// File: tb/wtc_cache_bench.sv
module wtc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    wtc_cache u_wtc_cache (.*);

    int checks = 0, errors = 0;
    logic [31:0] memw [4096];
    logic [31:0] refw [4096];
    logic [67:0] expq [256];
    int exp_wr = 0, exp_rd = 0, fill_count = 0, ready_mode = 1;
    int beats_left = 0, fill_base = 0;
    bit toggle = 0, hold_pend = 0, hold_wr = 0;
    logic [31:0] hold_addr = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // memory model: drives at negedge, samples handshakes for the coming edge
    always @(negedge clk) begin
        toggle = ~toggle;
        mem_req_ready = (ready_mode == 1) || (ready_mode == 2 && toggle);
        if (beats_left > 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = memw[fill_base + 8 - beats_left];
            beats_left--;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        #2;
        if (hold_pend)
            chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_write == hold_wr,
                "R9 request held", mem_req_addr, hold_addr);
        hold_pend = mem_req_valid && !mem_req_ready;
        hold_addr = mem_req_addr;
        hold_wr   = mem_req_write;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                chk(exp_rd != exp_wr, "R8 write without pending store", mem_req_addr, 32'h0);
                if (exp_rd != exp_wr) begin
                    chk(mem_req_addr == expq[exp_rd % 256][67:36], "R6 drain addr",
                        mem_req_addr, expq[exp_rd % 256][67:36]);
                    chk(mem_req_wdata == expq[exp_rd % 256][35:4] && mem_req_be == expq[exp_rd % 256][3:0],
                        "R6 drain data", mem_req_wdata, expq[exp_rd % 256][35:4]);
                    memw[mem_req_addr[13:2]] = merge(memw[mem_req_addr[13:2]], mem_req_wdata, mem_req_be);
                    exp_rd++;
                end
            end else begin
                chk(exp_rd == exp_wr, "R8 fill before drain", exp_wr - exp_rd, 0);
                chk(mem_req_addr[4:0] == 5'd0, "R3 line aligned", mem_req_addr, {mem_req_addr[31:5], 5'd0});
                fill_base = int'(mem_req_addr[13:2]);
                beats_left = 8;
                fill_count++;
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                          output logic [31:0] rd, output bit h, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be; cyc = 0;
        #3;
        h = cpu_hit;
        while (cpu_stall) begin
            @(negedge clk); #3; cyc++;
        end
        rd = cpu_rdata;
        if (we) begin
            expq[exp_wr % 256] = {a, d, be};
            exp_wr++;
            refw[a[13:2]] = merge(refw[a[13:2]], d, be);
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_rd != exp_wr) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return (32'(tag) << 10) | (32'(idx) << 5) | (32'(w) << 2);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, a;
        bit h;
        int cyc, f0;
        for (int i = 0; i < 4096; i++) begin
            memw[i] = (32'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;
            refw[i] = memw[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk(!cpu_stall, "R2 reset stall", 32'(cpu_stall), 0);
        chk(!mem_req_valid, "R2 reset mem idle", 32'(mem_req_valid), 0);

        // R1/R3: fill every line, then read each word back as a hit
        for (int idx = 0; idx < 32; idx++) begin
            a = mk(1, idx, idx % 8);
            f0 = fill_count;
            cpu_op(0, a, 0, 0, rd, h, cyc);
            chk(!h && cyc > 0, "R2 first read misses", 32'(h), 0);
            chk(rd == refw[a[13:2]], "R3 fill data", rd, refw[a[13:2]]);
            chk(fill_count == f0 + 1, "R3 single fill", 32'(fill_count - f0), 1);
            for (int w = 0; w < 8; w++) begin
                a = mk(1, idx, w);
                cpu_op(0, a, 0, 0, rd, h, cyc);
                chk(h && cyc == 0, "R1 hit no stall", 32'(cyc), 0);
                chk(rd == refw[a[13:2]], "R3 word order", rd, refw[a[13:2]]);
            end
        end

        // R1: conflicting tag on same index
        cpu_op(0, mk(2, 3, 0), 0, 0, rd, h, cyc);
        chk(!h, "R1 tag mismatch miss", 32'(h), 0);
        cpu_op(0, mk(1, 3, 0), 0, 0, rd, h, cyc);
        chk(!h, "R1 evicted miss", 32'(h), 0);

        // R4: all byte-enable patterns on cached words
        for (int be = 0; be < 16; be++) begin
            a = mk(1, 3, be % 8);
            cpu_op(1, a, 32'hA1B2_C3D4 + 32'(be), 4'(be), rd, h, cyc);
            chk(h && cyc == 0, "R4 store hit", 32'(cyc), 0);
            cpu_op(0, a, 0, 0, rd, h, cyc);
            chk(h && rd == refw[a[13:2]], "R4 byte merge", rd, refw[a[13:2]]);
        end
        wait_drain();

        // R5: store miss does not allocate
        a = mk(7, 9, 2);
        cpu_op(1, a, 32'hCAFE_0055, 4'hF, rd, h, cyc);
        chk(!h && cyc == 0, "R5 store miss accepted", 32'(h), 0);
        cpu_op(0, mk(1, 9, 2), 0, 0, rd, h, cyc);
        chk(h, "R5 resident line kept", 32'(h), 1);
        cpu_op(0, a, 0, 0, rd, h, cyc);
        chk(!h, "R5 no allocate", 32'(h), 0);
        chk(rd == 32'hCAFE_0055, "R5 value via memory", rd, 32'hCAFE_0055);
        wait_drain();

        // R7: saturate the store FIFO
        ready_mode = 0;
        for (int k = 0; k < 4; k++) begin
            cpu_op(1, mk(5, k, 1), 32'h1000 + 32'(k), 4'hF, rd, h, cyc);
            chk(cyc == 0, "R7 store accepted", 32'(cyc), 0);
        end
        fork
            cpu_op(1, mk(5, 4, 1), 32'h2000, 4'hF, rd, h, cyc);
            begin
                repeat (8) begin
                    @(negedge clk); #4;
                    chk(cpu_stall, "R7 full stalls", 32'(cpu_stall), 1);
                end
                ready_mode = 1;
            end
        join
        chk(cyc >= 8, "R7 stall length", 32'(cyc), 8);
        wait_drain();

        // R8: read miss waits for pending store
        ready_mode = 0;
        cpu_op(1, mk(3, 20, 0), 32'h0BAD_F00D, 4'h3, rd, h, cyc);
        a = mk(4, 21, 6);
        f0 = fill_count;
        fork
            cpu_op(0, a, 0, 0, rd, h, cyc);
            begin
                repeat (5) begin
                    @(negedge clk); #4;
                    chk(mem_req_valid && mem_req_write, "R8 fill held back", 32'(mem_req_write), 1);
                end
                ready_mode = 1;
            end
        join
        chk(rd == refw[a[13:2]], "R8 fill data", rd, refw[a[13:2]]);
        chk(fill_count == f0 + 1, "R8 one fill", 32'(fill_count - f0), 1);

        // R9/R6: alternating acceptance with mixed traffic
        ready_mode = 2;
        for (int k = 0; k < 12; k++) begin
            a = mk(8 + (k % 3), k, k % 8);
            cpu_op(k % 2, a, 32'h7700 + 32'(k), 4'(k + 1), rd, h, cyc);
            if (k % 2 == 0) chk(rd == refw[a[13:2]], "R9 read data", rd, refw[a[13:2]]);
        end
        ready_mode = 1;
        wait_drain();
        chk(exp_rd == exp_wr, "R6 all stores written", 32'(exp_rd), 32'(exp_wr));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule